// File: doc/BRIEF.md
# Response Ring Interrupt Controller

This block keeps the control and status state for a DMA engine that writes incoming responses into a ring in memory, and it decides when that engine raises its interrupt. Software reaches two 8-bit registers through a one-bit-address register port. One is a control register holding two interrupt enables and a run bit. The other is a status register holding two sticky flags that software clears by writing 1.

The datapath reports four things: one pulse per response stored in the ring, one pulse when a frame carries an empty response slot on every serial input, one pulse when the internal FIFO overflows, and a level that shows the engine is idle. The block returns the run request to the engine, both status flags and a single level-sensitive interrupt line. A response event is raised after a programmable number of stored responses or on an all-empty frame, whichever comes first. After software clears the run bit, that bit keeps reading 1 until the engine has actually gone idle.

Top module: `resp_ring_irq_ctrl`

## Requirements
- R1: After the asynchronous reset, both registers read 0x00 and dma_run_o, ovf_sts_o, resp_sts_o and irq_o are 0.
- R2: The control register sits at address 0. Bit 2 is the overrun interrupt enable, bit 1 is run and bit 0 is the response interrupt enable. Bits 2 and 0 read back what was last written, and bits 7:3 always read 0.
- R3: Writing 1 to control bit 1 drives dma_run_o high and makes bit 1 read 1, both from the clock edge that takes the write.
- R4: Writing 0 to control bit 1 drops dma_run_o at that edge. Bit 1 keeps reading 1 until dma_idle_i is sampled high on a later edge, and it reads 0 from that edge on.
- R5: While dma_run_o is high, the response pulse that brings the count of stored responses to resp_thresh_i sets response status (status bit 0) at that edge and restarts the count from zero. A threshold of 0 behaves as 1.
- R6: While dma_run_o is high, an all-empty-frame pulse sets response status at that edge and restarts the response count.
- R7: While dma_run_o is low, response and empty-frame pulses have no effect, and the response count is held at zero.
- R8: A FIFO overrun pulse sets overrun status (status bit 2) at that edge, whatever the enables and the run state.
- R9: The status register sits at address 1. Writing 1 to bit 2 or bit 0 clears that flag, and writing 0 leaves it unchanged. A set in the same cycle as the clear wins. Bits 7:3 and bit 1 read 0.
- R10: irq_o is high exactly when (overrun status AND overrun enable) OR (response status AND response enable), and it stays high until the flags or enables change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 1 | Register select: 0 control, 1 status |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of the selected register (combinational) |
| resp_thresh_i | input | CNT_W | Responses per response event (0 acts as 1) |
| resp_done_i | input | 1 | One response stored in the ring |
| empty_frame_i | input | 1 | Frame with an empty slot on all serial inputs |
| fifo_ovf_i | input | 1 | Internal FIFO overflowed and a response was dropped |
| dma_idle_i | input | 1 | Engine has fully stopped |
| dma_run_o | output | 1 | Run request to the engine |
| ovf_sts_o | output | 1 | Overrun status flag |
| resp_sts_o | output | 1 | Response status flag |
| irq_o | output | 1 | Interrupt, level-sensitive |

## Verification
Every register in the block updates on the edge that samples its cause. Status flags, dma_run_o and the readback of control bit 1 therefore change one edge after the event or write, and irq_o follows them in the same cycle with no further delay. Read data is combinational from the current state. The bench drives inputs on the falling edge. It checks reg_rdata_o 1 ns later against the model state before the edge, then checks every output 1 ns after the rising edge against the model advanced by one step. The only two-edge case is a stop: bit 1 clears one edge after dma_idle_i is seen following the write.

// File: rtl/rrc_pkg.sv
package rrc_pkg;
  localparam int unsigned REG_W    = 8;
  localparam logic        ADDR_CTL = 1'b0;
  localparam logic        ADDR_STS = 1'b1;
  localparam int unsigned BIT_RESP = 0;
  localparam int unsigned BIT_RUN  = 1;
  localparam int unsigned BIT_OVF  = 2;
  localparam int unsigned NUM_FLAG = 2;
  localparam int unsigned FLG_RESP = 0;
  localparam int unsigned FLG_OVF  = 1;
endpackage

// File: rtl/rrc_ctrl_reg.sv
module rrc_ctrl_reg
  import rrc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             dma_idle_i,
  output logic             ovf_ie_o,
  output logic             resp_ie_o,
  output logic             run_req_o,
  output logic             run_rb_o
);
  logic ovf_ie_q, resp_ie_q, run_req_q, run_rb_q;
  logic run_rb_d;

  // readback holds until the engine confirms idle after the request drops
  assign run_rb_d = (wr_i & wdata_i[BIT_RUN]) | run_req_q | (run_rb_q & ~dma_idle_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_ie_q  <= 1'b0;
      resp_ie_q <= 1'b0;
      run_req_q <= 1'b0;
      run_rb_q  <= 1'b0;
    end else begin
      run_rb_q <= run_rb_d;
      if (wr_i) begin
        ovf_ie_q  <= wdata_i[BIT_OVF];
        resp_ie_q <= wdata_i[BIT_RESP];
        run_req_q <= wdata_i[BIT_RUN];
      end
    end
  end

  assign ovf_ie_o  = ovf_ie_q;
  assign resp_ie_o = resp_ie_q;
  assign run_req_o = run_req_q;
  assign run_rb_o  = run_rb_q;
endmodule

// File: rtl/rrc_resp_cnt.sv
module rrc_resp_cnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             resp_i,
  input  logic             empty_i,
  input  logic [CNT_W-1:0] thresh_i,
  output logic             fire_o
);
  localparam int unsigned EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [EXT_W-1:0] cnt_inc, thr_eff;
  logic             hit;

  assign thr_eff = (thresh_i == '0) ? EXT_W'(1) : {1'b0, thresh_i};
  assign cnt_inc = {1'b0, cnt_q} + EXT_W'(1);
  assign hit     = resp_i & (cnt_inc >= thr_eff);
  assign fire_o  = run_i & (empty_i | hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || fire_o)  cnt_q <= '0;
    else if (resp_i)            cnt_q <= cnt_inc[CNT_W-1:0];
  end
endmodule

// File: rtl/rrc_status.sv
module rrc_status
  import rrc_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_FLAG-1:0] set_i,
  input  logic [NUM_FLAG-1:0] clr_i,
  output logic [NUM_FLAG-1:0] flag_o
);
  for (genvar g = 0; g < NUM_FLAG; g++) begin : g_flag
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (set_i[g]) q <= 1'b1;  // set beats a same-cycle clear
      else if (clr_i[g]) q <= 1'b0;
    end
    assign flag_o[g] = q;
  end
endmodule

// File: rtl/resp_ring_irq_ctrl.sv
module resp_ring_irq_ctrl
  import rrc_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_addr_i,
  input  logic             reg_we_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic [CNT_W-1:0] resp_thresh_i,
  input  logic             resp_done_i,
  input  logic             empty_frame_i,
  input  logic             fifo_ovf_i,
  input  logic             dma_idle_i,
  output logic             dma_run_o,
  output logic             ovf_sts_o,
  output logic             resp_sts_o,
  output logic             irq_o
);
  logic                wr_ctl, wr_sts;
  logic                ovf_ie, resp_ie, run_req, run_rb, fire;
  logic [NUM_FLAG-1:0] flg_set, flg_clr, flg;

  assign wr_ctl = reg_we_i & (reg_addr_i == ADDR_CTL);
  assign wr_sts = reg_we_i & (reg_addr_i == ADDR_STS);

  rrc_ctrl_reg u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_ctl),
    .wdata_i    (reg_wdata_i),
    .dma_idle_i (dma_idle_i),
    .ovf_ie_o   (ovf_ie),
    .resp_ie_o  (resp_ie),
    .run_req_o  (run_req),
    .run_rb_o   (run_rb)
  );

  rrc_resp_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_req),
    .resp_i   (resp_done_i),
    .empty_i  (empty_frame_i),
    .thresh_i (resp_thresh_i),
    .fire_o   (fire)
  );

  assign flg_set[FLG_RESP] = fire;
  assign flg_set[FLG_OVF]  = fifo_ovf_i;
  assign flg_clr[FLG_RESP] = wr_sts & reg_wdata_i[BIT_RESP];
  assign flg_clr[FLG_OVF]  = wr_sts & reg_wdata_i[BIT_OVF];

  rrc_status u_sts (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (flg_set),
    .clr_i  (flg_clr),
    .flag_o (flg)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_CTL) begin
      reg_rdata_o[BIT_OVF]  = ovf_ie;
      reg_rdata_o[BIT_RUN]  = run_rb;
      reg_rdata_o[BIT_RESP] = resp_ie;
    end else begin
      reg_rdata_o[BIT_OVF]  = flg[FLG_OVF];
      reg_rdata_o[BIT_RESP] = flg[FLG_RESP];
    end
  end

  assign dma_run_o  = run_req;
  assign ovf_sts_o  = flg[FLG_OVF];
  assign resp_sts_o = flg[FLG_RESP];
  assign irq_o      = (flg[FLG_OVF] & ovf_ie) | (flg[FLG_RESP] & resp_ie);
endmodule

// File: rtl/rrc_checker.sv
module rrc_checker
  import rrc_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_addr_i,
  input logic             reg_we_i,
  input logic [REG_W-1:0] reg_wdata_i,
  input logic [REG_W-1:0] reg_rdata_o,
  input logic             fifo_ovf_i,
  input logic             dma_idle_i,
  input logic             dma_run_o,
  input logic             run_rb,
  input logic             ovf_sts_o,
  input logic             resp_sts_o,
  input logic             irq_o
);
  logic run_wr1, ovf_clr, resp_clr;
  assign run_wr1  = reg_we_i && reg_addr_i == ADDR_CTL && reg_wdata_i[BIT_RUN];
  assign ovf_clr  = reg_we_i && reg_addr_i == ADDR_STS && reg_wdata_i[BIT_OVF];
  assign resp_clr = reg_we_i && reg_addr_i == ADDR_STS && reg_wdata_i[BIT_RESP];

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[REG_W-1:3] == '0); // R2

  AST_RUN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_wr1 |=> (dma_run_o && run_rb)); // R3

  AST_STOP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_rb && !dma_idle_i) |=> run_rb); // R4

  AST_STOP_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dma_run_o && dma_idle_i && !run_wr1) |=> !run_rb); // R4

  AST_IDLE_NO_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dma_run_o && !resp_sts_o) |=> !resp_sts_o); // R7

  AST_OVF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_ovf_i |=> ovf_sts_o); // R8

  AST_OVF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_clr && !fifo_ovf_i) |=> !ovf_sts_o); // R9

  AST_OVF_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_sts_o && !ovf_clr) |=> ovf_sts_o); // R9

  AST_RESP_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_sts_o && !resp_clr) |=> resp_sts_o); // R9

  AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !reg_we_i) |=> irq_o); // R10
endmodule

bind resp_ring_irq_ctrl rrc_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_addr_i  (reg_addr_i),
  .reg_we_i    (reg_we_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .fifo_ovf_i  (fifo_ovf_i),
  .dma_idle_i  (dma_idle_i),
  .dma_run_o   (dma_run_o),
  .run_rb      (run_rb),
  .ovf_sts_o   (ovf_sts_o),
  .resp_sts_o  (resp_sts_o),
  .irq_o       (irq_o)
);

// File: tb/sim_resp_ring_irq_ctrl.sv
`timescale 1ns/1ps
module sim_resp_ring_irq_ctrl;
  localparam int CNT_W = 8;
  localparam real HALF = 2.5;

  logic             clk_i = 1'b0, rst_ni = 1'b0;
  logic             reg_addr_i = 1'b0, reg_we_i = 1'b0;
  logic [7:0]       reg_wdata_i = '0, reg_rdata_o;
  logic [CNT_W-1:0] resp_thresh_i = '0;
  logic             resp_done_i = 1'b0, empty_frame_i = 1'b0;
  logic             fifo_ovf_i = 1'b0, dma_idle_i = 1'b0;
  logic             dma_run_o, ovf_sts_o, resp_sts_o, irq_o;

  int n_chk = 0, n_fail = 0;

  // model state
  bit m_ovf_ie, m_resp_ie, m_req, m_rb, m_ovf, m_resp;
  int m_cnt;

  always #(HALF) clk_i = ~clk_i;

  resp_ring_irq_ctrl #(.CNT_W(CNT_W)) u0 (.*);

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rdata(bit a);
    if (a == 1'b0) return {5'b0, m_ovf_ie, m_rb, m_resp_ie};
    return {5'b0, m_ovf, 1'b0, m_resp};
  endfunction

  function automatic bit exp_irq();
    return (m_ovf && m_ovf_ie) || (m_resp && m_resp_ie);
  endfunction

  task automatic model_step(bit we, bit a, logic [7:0] wd, bit rsp, bit emp, bit ovf, bit idle);
    bit wc = we && !a, ws = we && a;
    int eff = (resp_thresh_i == 0) ? 1 : int'(resp_thresh_i);
    bit fire = m_req && (emp || (rsp && (m_cnt + 1 >= eff)));
    bit n_rb = (wc && wd[1]) || m_req || (m_rb && !idle);
    if (!m_req || fire) m_cnt = 0;
    else if (rsp)       m_cnt = m_cnt + 1;
    m_ovf  = ovf  || (m_ovf  && !(ws && wd[2]));
    m_resp = fire || (m_resp && !(ws && wd[0]));
    m_rb = n_rb;
    if (wc) begin
      m_ovf_ie = wd[2]; m_req = wd[1]; m_resp_ie = wd[0];
    end
  endtask

  task automatic tick(bit we, bit a, logic [7:0] wd, bit rsp, bit emp, bit ovf, bit idle, string tag);
    @(negedge clk_i);
    reg_we_i = we; reg_addr_i = a; reg_wdata_i = wd;
    resp_done_i = rsp; empty_frame_i = emp; fifo_ovf_i = ovf; dma_idle_i = idle;
    #1;
    chk(a ? {tag, "/R9"} : {tag, "/R2"}, "reg_rdata_o", int'(reg_rdata_o), int'(exp_rdata(a)));
    @(posedge clk_i);
    model_step(we, a, wd, rsp, emp, ovf, idle);
    #1;
    chk({tag, "/R3"}, "dma_run_o", dma_run_o, m_req);
    chk({tag, "/R5"}, "resp_sts_o", resp_sts_o, m_resp);
    chk({tag, "/R8"}, "ovf_sts_o", ovf_sts_o, m_ovf);
    chk({tag, "/R10"}, "irq_o", irq_o, exp_irq());
  endtask

  task automatic idle_tick(string tag, bit idle = 1'b0);
    tick(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, idle, tag);
  endtask

  initial begin
    #(HALF * 2 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    #7;
    // R1: reset state
    chk("R1", "reg_rdata_o ctl", int'(reg_rdata_o), 0);
    chk("R1", "dma_run_o", dma_run_o, 0);
    chk("R1", "irq_o", irq_o, 0);
    reg_addr_i = 1'b1; #1;
    chk("R1", "reg_rdata_o sts", int'(reg_rdata_o), 0);
    reg_addr_i = 1'b0;
    rst_ni = 1'b1;
    resp_thresh_i = 8'd3;

    // R2/R3: write all ones, reserved bits read 0, run starts
    tick(1'b1, 1'b0, 8'hFF, 0, 0, 0, 0, "R2");
    chk("R2", "ctl readback", int'(exp_rdata(0)), 8'h07);
    idle_tick("R3");
    // R5: three responses fire the event
    tick(0, 0, 8'h00, 1, 0, 0, 0, "R5");
    tick(0, 0, 8'h00, 1, 0, 0, 0, "R5");
    chk("R5", "resp_sts_o early", resp_sts_o, 0);
    tick(0, 0, 8'h00, 1, 0, 0, 0, "R5");
    chk("R5", "resp_sts_o at N", resp_sts_o, 1);
    // R9: clear, then set-wins collision
    tick(1, 1, 8'h01, 0, 0, 0, 0, "R9");
    chk("R9", "resp_sts_o cleared", resp_sts_o, 0);
    tick(1, 1, 8'h00, 0, 0, 1, 0, "R8");
    tick(1, 1, 8'h04, 0, 1, 1, 0, "R9");
    chk("R9", "ovf set wins", ovf_sts_o, 1);
    // R6: empty frame fired above; count restarted
    chk("R6", "resp_sts_o empty frame", resp_sts_o, 1);
    tick(1, 1, 8'h05, 0, 0, 0, 0, "R9");
    // R4: stop with engine busy
    tick(1, 0, 8'h05, 0, 0, 0, 0, "R4");
    chk("R4", "dma_run_o dropped", dma_run_o, 0);
    for (int i = 0; i < 4; i++) idle_tick("R4");
    chk("R4", "run readback busy", int'(exp_rdata(0)), 8'h07);
    idle_tick("R4", 1'b1);
    idle_tick("R4", 1'b0);
    // R7: events ignored while stopped
    for (int i = 0; i < 5; i++) tick(0, 0, 8'h00, 1, i == 2, 0, 1, "R7");
    chk("R7", "resp_sts_o stopped", resp_sts_o, 0);
    // R5: threshold 0 acts as 1
    resp_thresh_i = '0;
    tick(1, 0, 8'h03, 0, 0, 0, 1, "R5");
    tick(0, 0, 8'h00, 1, 0, 0, 1, "R5");
    chk("R5", "thresh 0 fires", resp_sts_o, 1);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      bit we = ($urandom % 8) == 0;
      if (($urandom % 64) == 0) resp_thresh_i = CNT_W'($urandom % 6);
      tick(we, 1'($urandom), 8'($urandom), ($urandom % 3) == 0,
           ($urandom % 16) == 0, ($urandom % 32) == 0, 1'($urandom), "rnd");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule